// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Refresh

This block drives an asynchronous DRAM that has a 16-bit bidirectional data bus and a 10-bit address bus shared between row and column. A client raises a request with a word address, a read/write flag and write data. The controller runs one complete strobe sequence: row phase, column phase, then precharge. It returns a one-clock done pulse and, for reads, the word it captured from the bus. The pad buffers are not part of the block. The data bus appears as separate in, out and drive-enable signals, and the bench models the pulled-low idle bus.

A free-running timer schedules CAS-before-RAS refresh cycles. Its interval is derived from the clock frequency and from a 1024-row array. A mode input selects whether the whole array is refreshed once per 8.2 ms or once per 128 ms. The fast setting is safe for both array sizes. A pending refresh takes the next free slot ahead of a waiting request but never cuts into an access already under way. A size input selects the 16 Mbit mapping (ten row and ten column bits) or the 4 Mbit mapping (nine and nine), in which the top address pin stays low.

Top module: `mux_dram_ctrl`

## Requirements
- R1: While reset is asserted, and after it until a request or refresh is due, all four strobes are high, the bus drive enable is low and done is low.
- R2: An access holds the row strobe low alone for T_ROW clocks, then holds row and column strobes low together for T_COL clocks, then holds all strobes high for at least T_PRE clocks.
- R3: With array_16m=1 the address pins carry req_addr[19:10] during the row phase and req_addr[9:0] during the column phase. With array_16m=0 they carry req_addr[17:9] and req_addr[8:0], and pin 9 is always 0.
- R4: During the column phase of a write, the write strobe is low, the output-enable strobe is high, the bus drive enable is high and the bus output equals the request's write data.
- R5: During the column phase of a read, the output-enable strobe is low, the write strobe is high and the bus is not driven. rd_data holds the bus value from the last column clock.
- R6: done is high for exactly one clock, in the first precharge clock of an access, with all strobes high.
- R7: A refresh lowers the column strobe for T_RCAS clocks with the row strobe high, then both strobes for T_RRAS clocks, and asserts neither the write nor the output-enable strobe.
- R8: With refresh_slow=0, refresh cycles start every floor(CLK_KHZ*82/10240) clocks while the bus is idle. With refresh_slow=1 they start every floor(CLK_KHZ*128/1024) clocks.
- R9: When a refresh falls due during an access, that access completes unchanged, and the refresh runs before a request still waiting.
- R10: The write and output-enable strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_slow | input | 1 | 0: whole array refreshed per 8.2 ms; 1: per 128 ms |
| array_16m | input | 1 | 1: 10+10 address mapping; 0: 9+9 mapping with pin 9 low |
| req | input | 1 | Access request, held until done |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read word |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven to the bus |
| dram_dq_oe | output | 1 | Bus drive enable |
| dram_dq_in | input | 16 | Data sampled from the bus |

## Verification
A wrong sequencer state shows at the strobes in the very next clock. Examples are a phase counter loaded with the wrong length, a column phase entered early, or a refresh started while an access is open. The bench counts strobe-low clocks per phase for each access and each refresh. A misrouted address bit shows in the row or column value captured on the pins. A read captured on the wrong clock returns a bus value different from the one the bench model presented. A wrong refresh limit or mode decode only shows as a shifted interval between refresh starts: within one 160-clock period in fast mode, or one 2500-clock period in slow mode.

// File: rtl/mdram_pkg.sv
package mdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_PRE  = 3'd3,
        ST_RCAS = 3'd4,
        ST_RRAS = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
        logic col_sel;
    } strobe_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mdram_refresh_timer.sv
module mdram_refresh_timer #(
    parameter int CLK_KHZ = 200000,
    parameter int ROWS    = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_mode,
    input  logic grant,
    output logic pending
);
    localparam int FAST_LIM = (CLK_KHZ * 82) / (10 * ROWS);
    localparam int SLOW_LIM = (CLK_KHZ * 128) / ROWS;
    localparam int CW       = $clog2(SLOW_LIM + 1);
    localparam logic [CW-1:0] FAST_M1 = CW'(FAST_LIM - 1);
    localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_LIM - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] last_d;

    always_comb begin
        tmr_d  = tmr_q;
        last_d = slow_mode ? SLOW_M1 : FAST_M1;
        if (grant) begin
            tmr_d.pend = 1'b0;
        end
        if (tmr_q.cnt >= last_d) begin
            tmr_d.cnt  = '0;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign pending = tmr_q.pend;

endmodule

// File: rtl/mdram_addr_mux.sv
module mdram_addr_mux #(
    parameter int ROW_W = 10
) (
    input  logic [2*ROW_W-1:0] addr,
    input  logic               wide,
    input  logic               col_sel,
    output logic [ROW_W-1:0]   pins
);
    logic [ROW_W-1:0] row_d, col_d;

    always_comb begin
        if (wide) begin
            row_d = addr[2*ROW_W-1:ROW_W];
            col_d = addr[ROW_W-1:0];
        end else begin
            row_d = {1'b0, addr[2*ROW_W-3:ROW_W-1]};
            col_d = {1'b0, addr[ROW_W-2:0]};
        end
        pins = col_sel ? col_d : row_d;
    end

endmodule

// File: rtl/mdram_seq.sv
module mdram_seq
    import mdram_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int T_ROW  = 3,
    parameter int T_COL  = 3,
    parameter int T_PRE  = 3,
    parameter int T_RCAS = 2,
    parameter int T_RRAS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ref_pend,
    input  logic [DW-1:0] dq_in,
    output logic          ref_grant,
    output strobe_t       strb,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    localparam int TMAX  = imax(imax(imax(T_ROW, T_COL), imax(T_PRE, T_RCAS)), T_RRAS);
    localparam int CNT_W = imax($clog2(TMAX + 1), 1);

    typedef struct packed {
        seq_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic           we;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        ref_grant = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_grant = 1'b1;
                    s_d.state = ST_RCAS;
                    s_d.cnt   = CNT_W'(T_RCAS - 1);
                end else if (req) begin
                    s_d.state = ST_ROW;
                    s_d.cnt   = CNT_W'(T_ROW - 1);
                    s_d.we    = req_we;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_COL;
                    s_d.cnt   = CNT_W'(T_COL - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = CNT_W'(T_PRE - 1);
                    s_d.done  = 1'b1;
                    if (!s_q.we) begin
                        s_d.rdata = dq_in;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RCAS: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_RRAS;
                    s_d.cnt   = CNT_W'(T_RRAS - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RRAS: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_PRE;
                    s_d.cnt   = CNT_W'(T_PRE - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // strobe decode from the registered phase
    always_comb begin
        strb = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                 dq_oe: 1'b0, col_sel: 1'b0};
        unique case (s_q.state)
            ST_ROW: begin
                strb.ras_n = 1'b0;
            end
            ST_COL: begin
                strb.ras_n   = 1'b0;
                strb.cas_n   = 1'b0;
                strb.col_sel = 1'b1;
                strb.we_n    = ~s_q.we;
                strb.oe_n    = s_q.we;
                strb.dq_oe   = s_q.we;
            end
            ST_RCAS: begin
                strb.cas_n = 1'b0;
            end
            ST_RRAS: begin
                strb.cas_n = 1'b0;
                strb.ras_n = 1'b0;
            end
            default: begin
                strb.col_sel = (s_q.state == ST_PRE);
            end
        endcase
    end

    assign acc_addr = s_q.addr;
    assign dq_out   = s_q.wdata;
    assign rd_data  = s_q.rdata;
    assign done     = s_q.done;

endmodule

// File: rtl/mux_dram_ctrl.sv
module mux_dram_ctrl
    import mdram_pkg::*;
#(
    parameter int CLK_KHZ = 200000,
    parameter int ROW_W   = 10,
    parameter int DW      = 16,
    parameter int T_ROW   = 3,
    parameter int T_COL   = 3,
    parameter int T_PRE   = 3,
    parameter int T_RCAS  = 2,
    parameter int T_RRAS  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                refresh_slow,
    input  logic                array_16m,
    input  logic                req,
    input  logic                req_we,
    input  logic [2*ROW_W-1:0]  req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                done,
    output logic [DW-1:0]       rd_data,
    output logic [ROW_W-1:0]    dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [DW-1:0]       dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DW-1:0]       dram_dq_in
);
    localparam int AW       = 2 * ROW_W;
    localparam int REF_ROWS = 1 << ROW_W;

    logic          ref_pend, ref_grant;
    strobe_t       strb;
    logic [AW-1:0] acc_addr;

    mdram_refresh_timer #(
        .CLK_KHZ (CLK_KHZ),
        .ROWS    (REF_ROWS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (refresh_slow),
        .grant     (ref_grant),
        .pending   (ref_pend)
    );

    mdram_seq #(
        .AW     (AW),
        .DW     (DW),
        .T_ROW  (T_ROW),
        .T_COL  (T_COL),
        .T_PRE  (T_PRE),
        .T_RCAS (T_RCAS),
        .T_RRAS (T_RRAS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ref_pend  (ref_pend),
        .dq_in     (dram_dq_in),
        .ref_grant (ref_grant),
        .strb      (strb),
        .acc_addr  (acc_addr),
        .dq_out    (dram_dq_out),
        .rd_data   (rd_data),
        .done      (done)
    );

    mdram_addr_mux #(
        .ROW_W (ROW_W)
    ) u_amux (
        .addr    (acc_addr),
        .wide    (array_16m),
        .col_sel (strb.col_sel),
        .pins    (dram_addr)
    );

    assign dram_ras_n = strb.ras_n;
    assign dram_cas_n = strb.cas_n;
    assign dram_we_n  = strb.we_n;
    assign dram_oe_n  = strb.oe_n;
    assign dram_dq_oe = strb.dq_oe;

endmodule

// File: rtl/mux_dram_ctrl_chk.sv
module mux_dram_ctrl_chk #(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             array_16m,
    input logic             done,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe
);
    // R1: quiet bus while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n
                                      && !dram_dq_oe && !done)
                else $error("R1 bus not quiet in reset");
        end
    end

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n));

    a_r4_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && !dram_cas_n && !dram_ras_n));

    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_oe_n |-> !dram_dq_oe);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_in_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dram_ras_n && dram_cas_n));

    a_r7_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

    a_r7_refresh_no_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && dram_ras_n) |-> (dram_we_n && dram_oe_n));

    a_r3_top_pin_small: assert property (@(posedge clk) disable iff (!rst_n)
        !array_16m |-> !dram_addr[ROW_W-1]);

endmodule

bind mux_dram_ctrl mux_dram_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .array_16m  (array_16m),
    .done       (done),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_oe (dram_dq_oe)
);

// File: tb/mux_dram_ctrl_test.sv
module mux_dram_ctrl_test;
    localparam int CLK_KHZ = 20000;
    localparam int T_ROW   = 2;
    localparam int T_COL   = 3;
    localparam int T_PRE   = 2;
    localparam int T_RCAS  = 1;
    localparam int T_RRAS  = 3;
    localparam int FAST_P  = (CLK_KHZ * 82) / 10240;
    localparam int SLOW_P  = (CLK_KHZ * 128) / 1024;
    localparam int NV      = 8;

    // vector: {we, wide, addr[19:0], wdata[15:0]}
    localparam logic [37:0] VEC [NV] = '{
        {1'b1, 1'b1, 20'hABCDE, 16'h1234},
        {1'b0, 1'b1, 20'hABCDE, 16'h0000},
        {1'b1, 1'b1, 20'hFFFFF, 16'hFFFF},
        {1'b0, 1'b1, 20'h00000, 16'h0000},
        {1'b0, 1'b1, 20'h80201, 16'h0000},
        {1'b1, 1'b0, 20'hFFFFF, 16'hA5A5},
        {1'b0, 1'b0, 20'h3FE01, 16'h0000},
        {1'b0, 1'b0, 20'hC0200, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh_slow = 1'b0;
    logic        array_16m = 1'b1;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [15:0] dram_dq_out;
    logic        dram_dq_oe;
    logic [15:0] dram_dq_in;
    logic [9:0]  row_lat = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bus model: pulled low unless the part drives it for a read
    always @(negedge dram_ras_n) row_lat = dram_addr;
    assign dram_dq_in = dram_oe_n ? 16'h0000 : {row_lat[5:0] ^ 6'h2A, dram_addr};

    mux_dram_ctrl #(
        .CLK_KHZ (CLK_KHZ),
        .T_ROW   (T_ROW),
        .T_COL   (T_COL),
        .T_PRE   (T_PRE),
        .T_RCAS  (T_RCAS),
        .T_RRAS  (T_RRAS)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_slow (refresh_slow),
        .array_16m    (array_16m),
        .req          (req),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .done         (done),
        .rd_data      (rd_data),
        .dram_addr    (dram_addr),
        .dram_ras_n   (dram_ras_n),
        .dram_cas_n   (dram_cas_n),
        .dram_we_n    (dram_we_n),
        .dram_oe_n    (dram_oe_n),
        .dram_dq_out  (dram_dq_out),
        .dram_dq_oe   (dram_dq_oe),
        .dram_dq_in   (dram_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] exp_row(input logic [19:0] a, input logic w);
        return w ? a[19:10] : {1'b0, a[17:9]};
    endfunction

    function automatic logic [9:0] exp_col(input logic [19:0] a, input logic w);
        return w ? a[9:0] : {1'b0, a[8:0]};
    endfunction

    function automatic bit quiet();
        return dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe;
    endfunction

    // one access, called at a negative edge
    task automatic do_access(input logic [37:0] v, input bit keep);
        int rowcnt = 0;
        int colcnt = 0;
        int badrw = 0;
        int broke = 0;
        logic [9:0] row_seen = '0;
        logic [9:0] col_seen = '0;
        logic [9:0] er, ec;
        req_we    = v[37];
        array_16m = v[36];
        req_addr  = v[35:16];
        req_wdata = v[15:0];
        req       = 1'b1;
        er = exp_row(v[35:16], v[36]);
        ec = exp_col(v[35:16], v[36]);
        forever begin
            @(negedge clk);
            if (!dram_ras_n && dram_cas_n) begin
                if (rowcnt == 0) row_seen = dram_addr;
                rowcnt++;
            end else if (!dram_ras_n && !dram_cas_n && rowcnt > 0) begin
                if (colcnt == 0) col_seen = dram_addr;
                colcnt++;
                if (v[37]) begin
                    if (dram_we_n || !dram_oe_n || !dram_dq_oe || dram_dq_out != v[15:0])
                        badrw++;
                end else begin
                    if (!dram_we_n || dram_oe_n || dram_dq_oe) badrw++;
                end
            end else if (dram_ras_n && !dram_cas_n && rowcnt > 0) begin
                broke++;
            end
            if (done) break;
        end
        chk(quiet(), "R6 done with strobes high", {27'd0, dram_ras_n, dram_cas_n,
            dram_we_n, dram_oe_n, dram_dq_oe}, 32'h1E);
        if (!keep) req = 1'b0;
        chk(rowcnt == T_ROW, "R2 row phase length", rowcnt, T_ROW);
        chk(colcnt == T_COL, "R2 column phase length", colcnt, T_COL);
        chk(broke == 0, "R9 access not interrupted", broke, 0);
        chk(row_seen == er, "R3 row address", row_seen, er);
        chk(col_seen == ec, "R3 column address", col_seen, ec);
        if (v[37]) chk(badrw == 0, "R4 write column strobes and data", badrw, 0);
        else begin
            chk(badrw == 0, "R5 read column strobes", badrw, 0);
            chk(rd_data == {er[5:0] ^ 6'h2A, ec}, "R5 read data",
                rd_data, {er[5:0] ^ 6'h2A, ec});
        end
        @(negedge clk);
        chk(!done, "R6 done single clock", done, 0);
        for (int k = 1; k < T_PRE; k++) begin
            chk(quiet(), "R2 precharge strobes high", dram_ras_n, 1);
            if (k + 1 < T_PRE) @(negedge clk);
        end
    endtask

    // wait for a refresh start and check its shape; returns the start cycle
    task automatic wait_cbr(output int start);
        int rc = 0;
        int rr = 0;
        int bad = 0;
        forever begin
            @(negedge clk);
            if (!dram_cas_n && dram_ras_n) break;
        end
        start = cyc;
        while (!dram_cas_n && dram_ras_n) begin
            rc++;
            if (!dram_we_n || !dram_oe_n) bad++;
            @(negedge clk);
        end
        while (!dram_cas_n && !dram_ras_n) begin
            rr++;
            if (!dram_we_n || !dram_oe_n) bad++;
            @(negedge clk);
        end
        chk(rc == T_RCAS, "R7 column-first phase length", rc, T_RCAS);
        chk(rr == T_RRAS, "R7 both-strobe phase length", rr, T_RRAS);
        chk(bad == 0, "R7 no read or write strobe", bad, 0);
        chk(quiet(), "R7 precharge after refresh", dram_ras_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG run did not finish", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        repeat (3) @(negedge clk);
        chk(quiet() && !done, "R1 quiet during reset", dram_ras_n, 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(quiet() && !done, "R1 quiet after reset", dram_ras_n, 1);

        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i], 1'b0);
            @(negedge clk);
        end
        array_16m = 1'b1;

        // R8 fast interval
        refresh_slow = 1'b0;
        wait_cbr(t1);
        wait_cbr(t2);
        chk(t2 - t1 == FAST_P, "R8 fast refresh interval", t2 - t1, FAST_P);

        // R9 refresh due during an access with a second request waiting
        wait_cbr(t0);
        while (cyc < t0 + FAST_P - 6) @(negedge clk);
        do_access({1'b0, 1'b1, 20'h12345, 16'h0}, 1'b1);
        forever begin
            @(negedge clk);
            if (!dram_ras_n || !dram_cas_n) break;
        end
        chk(!dram_cas_n && dram_ras_n, "R9 refresh before waiting request",
            {dram_ras_n, dram_cas_n}, 2'b10);
        do_access({1'b1, 1'b1, 20'h12345, 16'hBEEF}, 1'b0);

        // R8 slow interval
        refresh_slow = 1'b1;
        wait_cbr(t1);
        wait_cbr(t1);
        wait_cbr(t2);
        chk(t2 - t1 == SLOW_P, "R8 slow refresh interval", t2 - t1, SLOW_P);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule